// File: doc/BRIEF.md
# Physical Address Memory Type Resolver

This block decides the memory type that applies to a physical address. Configuration registers are held elsewhere. Their decoded fields come in as plain inputs: a global enable, a fixed-region enable, a default type, eleven 64-bit words of fixed-region type bytes, and a set of variable ranges. Each variable range has a base, a mask, a type and a valid bit. The block is a lookup with a one-cycle registered result.

The resolution runs in a fixed order:

1. When the global enable is clear, the result is uncached.
2. Otherwise, the fixed sub-range map for the first megabyte is used when the address lies in that megabyte and the fixed region is enabled.
3. Otherwise, the variable ranges are matched by base and mask. Overlapping matches are combined by priority rules.
4. If nothing matches, the default type is used.

A match set that the rules do not define raises a flag, and the type is then forced to uncached.

Top module: `mem_type_resolver`

## Requirements
- R1: When `glb_en` is 0, the registered result is type 0 (UC) and `undef_ovl` is 0, whatever the other inputs are.
- R2: With `glb_en` and `fix_en` set, an address below 0x80000 takes its type from bits [2:0] of byte `addr[18:16]` of fixed word 0. Word w occupies `fix_words[w*64 +: 64]`, and byte b of a word occupies bits `[b*8 +: 8]`.
- R3: An address in 0x80000–0xBFFFF uses fixed word 1 (from 0x80000) or word 2 (from 0xA0000), with 16 KB bytes indexed by `addr[16:14]`.
- R4: An address in 0xC0000–0xFFFFF uses fixed word 3 + `addr[17:15]`, with 4 KB bytes indexed by `addr[14:12]`.
- R5: When `fix_en` is 0, addresses below 1 MB resolve through the variable ranges and the default type, exactly like higher addresses.
- R6: A fixed-region hit takes priority over any variable match and never raises `undef_ovl`.
- R7: Variable pair i matches when `var_valid[i]` is 1 and `(addr[PA_W-1:12] & mask_i) == (base_i & mask_i)`. Field i is `[i*(PA_W-12) +: PA_W-12]`. Its type is `var_type[i*3 +: 3]`.
- R8: When all matching pairs carry the same type, that type is the result and `undef_ovl` is 0.
- R9: When any matching pair has type 0 (UC), the result is UC and `undef_ovl` is 0.
- R10: When the set of matching types is exactly {4 (WT), 6 (WB)}, the result is WT.
- R11: Any other mixed match set sets `undef_ovl` to 1 and forces the result to UC.
- R12: When no fixed or variable range matches, the result is `dflt_type`.
- R13: The outputs are registered. They show the resolution of the inputs present at the previous rising edge. During reset they read UC with `undef_ovl` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | PA_W | Physical address to resolve |
| glb_en | input | 1 | Global enable for all range typing |
| fix_en | input | 1 | Enable for the first-megabyte fixed map |
| dflt_type | input | 3 | Type used when nothing matches |
| fix_words | input | 11*64 | Fixed-region type bytes, eight per word |
| var_base | input | NVAR*(PA_W-12) | Variable range bases, address bits 12 and up |
| var_mask | input | NVAR*(PA_W-12) | Variable range masks, address bits 12 and up |
| var_type | input | NVAR*3 | Variable range types |
| var_valid | input | NVAR | Variable range valid bits |
| mem_type | output | 3 | Resolved memory type |
| undef_ovl | output | 1 | Undefined overlap combination seen |

## Verification
Both outputs are due exactly one rising edge after the inputs they depend on. The bench drives new inputs on the falling edge. At each rising edge it computes the expected pair from the inputs that are stable at that moment. It then compares the outputs 2 ns later, before the next falling edge changes anything. Reset cycles expect UC with the flag low. The bound checker relates each registered output to the `$past` value of the inputs and of the internal hit signals.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam logic [2:0] MT_UC = 3'd0;
  localparam logic [2:0] MT_WC = 3'd1;
  localparam logic [2:0] MT_WT = 3'd4;
  localparam logic [2:0] MT_WP = 3'd5;
  localparam logic [2:0] MT_WB = 3'd6;
  localparam int FIX_WORDS = 11;
  localparam int FIX_BITS  = FIX_WORDS * 64;

  // which fixed word covers an address inside the first megabyte
  function automatic logic [3:0] fix_word_of(input logic [19:0] a);
    if (!a[19])      return 4'd0;
    else if (!a[18]) return 4'd1 + {3'd0, a[17]};
    else             return 4'd3 + {1'b0, a[17:15]};
  endfunction

  // which byte inside that word
  function automatic logic [2:0] fix_byte_of(input logic [19:0] a);
    if (!a[19])      return a[18:16];
    else if (!a[18]) return a[16:14];
    else             return a[14:12];
  endfunction

  // onehot of type codes -> code
  function automatic logic [2:0] code_of(input logic [7:0] oh);
    logic [2:0] c;
    c = 3'd0;
    for (int k = 0; k < 8; k++)
      if (oh[k]) c = 3'(k);
    return c;
  endfunction
endpackage

// File: rtl/mtr_fixed_lookup.sv
module mtr_fixed_lookup
  import mtr_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [PA_W-1:0]     addr,
  input  logic                fix_en,
  input  logic [FIX_BITS-1:0] fix_words,
  output logic                hit,
  output logic [2:0]          ftype
);
  localparam int HI_W = PA_W - 20;

  logic [3:0] widx;
  logic [2:0] bidx;
  logic [7:0] sel_byte;

  always_comb begin
    widx     = fix_word_of(addr[19:0]);
    bidx     = fix_byte_of(addr[19:0]);
    sel_byte = fix_words[int'(widx)*64 + int'(bidx)*8 +: 8];
    hit      = fix_en && (addr[PA_W-1:20] == {HI_W{1'b0}});
    ftype    = sel_byte[2:0];
  end
endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match #(
  parameter int PA_W = 36,
  parameter int NVAR = 8
) (
  input  logic [PA_W-1:0]           addr,
  input  logic [NVAR*(PA_W-12)-1:0] var_base,
  input  logic [NVAR*(PA_W-12)-1:0] var_mask,
  input  logic [NVAR*3-1:0]         var_type,
  input  logic [NVAR-1:0]           var_valid,
  output logic [NVAR-1:0]           hit_vec,
  output logic [7:0]                seen
);
  localparam int FW = PA_W - 12;

  logic [FW-1:0] page;
  assign page = addr[PA_W-1:12];

  for (genvar i = 0; i < NVAR; i++) begin : g_pair
    logic [FW-1:0] b, m;
    assign b = var_base[i*FW +: FW];
    assign m = var_mask[i*FW +: FW];
    assign hit_vec[i] = var_valid[i] && ((page & m) == (b & m));
  end

  always_comb begin
    seen = 8'd0;
    for (int i = 0; i < NVAR; i++)
      if (hit_vec[i]) seen[var_type[i*3 +: 3]] = 1'b1;
  end
endmodule

// File: rtl/mtr_overlap_resolve.sv
module mtr_overlap_resolve
  import mtr_pkg::*;
(
  input  logic [7:0] seen,
  output logic       any,
  output logic [2:0] rtype,
  output logic       undef
);
  localparam logic [7:0] WT_WB = (8'd1 << MT_WT) | (8'd1 << MT_WB);

  always_comb begin
    any   = |seen;
    rtype = MT_UC;
    undef = 1'b0;
    if (seen[MT_UC])                rtype = MT_UC;
    else if ($countones(seen) == 1) rtype = code_of(seen);
    else if (seen == WT_WB)         rtype = MT_WT;
    else if (any)                   undef = 1'b1;
  end
endmodule

// File: rtl/mem_type_resolver.sv
module mem_type_resolver
  import mtr_pkg::*;
#(
  parameter int PA_W = 36,
  parameter int NVAR = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PA_W-1:0]           addr,
  input  logic                      glb_en,
  input  logic                      fix_en,
  input  logic [2:0]                dflt_type,
  input  logic [FIX_BITS-1:0]       fix_words,
  input  logic [NVAR*(PA_W-12)-1:0] var_base,
  input  logic [NVAR*(PA_W-12)-1:0] var_mask,
  input  logic [NVAR*3-1:0]         var_type,
  input  logic [NVAR-1:0]           var_valid,
  output logic [2:0]                mem_type,
  output logic                      undef_ovl
);
  // named internal events, observed by the bound checker
  logic            fix_hit;
  logic [2:0]      fix_type;
  logic [NVAR-1:0] var_hits;
  logic [7:0]      var_seen;
  logic            var_any;
  logic [2:0]      var_rtype;
  logic            var_undef;
  logic [2:0]      nxt_type;
  logic            nxt_undef;

  mtr_fixed_lookup #(.PA_W(PA_W)) u_fix (
    .addr(addr), .fix_en(fix_en), .fix_words(fix_words),
    .hit(fix_hit), .ftype(fix_type)
  );

  mtr_var_match #(.PA_W(PA_W), .NVAR(NVAR)) u_var (
    .addr(addr), .var_base(var_base), .var_mask(var_mask),
    .var_type(var_type), .var_valid(var_valid),
    .hit_vec(var_hits), .seen(var_seen)
  );

  mtr_overlap_resolve u_ovl (
    .seen(var_seen), .any(var_any), .rtype(var_rtype), .undef(var_undef)
  );

  always_comb begin
    nxt_type  = dflt_type;
    nxt_undef = 1'b0;
    if (!glb_en) begin
      nxt_type = MT_UC;
    end else if (fix_hit) begin
      nxt_type = fix_type;
    end else if (var_any) begin
      nxt_type  = var_rtype;
      nxt_undef = var_undef;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_type  <= MT_UC;
      undef_ovl <= 1'b0;
    end else begin
      mem_type  <= nxt_type;
      undef_ovl <= nxt_undef;
    end
  end
endmodule

// File: rtl/mtr_checker.sv
module mtr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic [2:0] dflt_type,
  input logic       fix_hit,
  input logic [2:0] fix_type,
  input logic [7:0] var_seen,
  input logic [2:0] mem_type,
  input logic       undef_ovl
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_glb_off_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(!glb_en) |-> (mem_type == 3'd0 && !undef_ovl));

  assert_fixed_wins_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(glb_en && fix_hit) |-> (mem_type == $past(fix_type) && !undef_ovl));

  assert_single_type_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(glb_en && !fix_hit && $countones(var_seen) == 1) |-> !undef_ovl);

  assert_uc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(glb_en && !fix_hit && var_seen[0]) |-> (mem_type == 3'd0 && !undef_ovl));

  assert_undef_forces_uc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    undef_ovl |-> mem_type == 3'd0);

  assert_default_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(glb_en && !fix_hit && var_seen == 8'd0) |-> (mem_type == $past(dflt_type) && !undef_ovl));
endmodule

bind mem_type_resolver mtr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .dflt_type(dflt_type),
  .fix_hit(fix_hit), .fix_type(fix_type), .var_seen(var_seen),
  .mem_type(mem_type), .undef_ovl(undef_ovl)
);

// File: tb/tb_mem_type_resolver.sv
`timescale 1ns/1ps
module tb_mem_type_resolver;
  localparam int PA_W = 36;
  localparam int NVAR = 8;
  localparam int FW   = PA_W - 12;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [PA_W-1:0]      addr = '0;
  logic                 glb_en = 1'b0, fix_en = 1'b0;
  logic [2:0]           dflt_type = 3'd6;
  logic [11*64-1:0]     fix_words = '0;
  logic [NVAR*FW-1:0]   var_base = '0, var_mask = '0;
  logic [NVAR*3-1:0]    var_type = '0;
  logic [NVAR-1:0]      var_valid = '0;
  logic [2:0]           mem_type;
  logic                 undef_ovl;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R13";

  mem_type_resolver #(.PA_W(PA_W), .NVAR(NVAR)) dut (.*);

  always #4 clk = ~clk;

  // behavioural reference: integer arithmetic over the requirement text
  task automatic model(output int t, output int u);
    longint a;
    int q[$];
    bit uc, wt, wb, other, same;
    int w, b;
    a = longint'(addr);
    u = 0;
    if (!rst_n || !glb_en) begin t = 0; return; end
    if (fix_en && a < 64'h100000) begin
      if (a < 'h80000)      begin w = 0;                          b = int'(a / 'h10000); end
      else if (a < 'hC0000) begin w = 1 + int'((a - 'h80000) / 'h20000); b = int'((a % 'h20000) / 'h4000); end
      else                  begin w = 3 + int'((a - 'hC0000) / 'h8000);  b = int'((a % 'h8000) / 'h1000); end
      t = int'(fix_words[w*64 + b*8 +: 3]);
      return;
    end
    for (int i = 0; i < NVAR; i++) begin
      longint bs, mk;
      bs = longint'(var_base[i*FW +: FW]) * 4096;
      mk = longint'(var_mask[i*FW +: FW]) * 4096;
      if (var_valid[i] && ((a & mk) == (bs & mk))) q.push_back(int'(var_type[i*3 +: 3]));
    end
    if (q.size() == 0) begin t = int'(dflt_type); return; end
    uc = 0; wt = 0; wb = 0; other = 0; same = 1;
    foreach (q[k]) begin
      if (q[k] == 0) uc = 1;
      else if (q[k] == 4) wt = 1;
      else if (q[k] == 6) wb = 1;
      else other = 1;
      if (q[k] != q[0]) same = 0;
    end
    if (uc) t = 0;
    else if (same) t = q[0];
    else if (wt && wb && !other) t = 4;
    else begin t = 0; u = 1; end
  endtask

  // compare on every clock, 2 ns after the edge that loaded the result
  always @(posedge clk) begin
    int et, eu;
    string tg;
    if (!done) begin
      model(et, eu);
      tg = tag;
      #2;
      total++;
      if (int'(mem_type) != et || int'(undef_ovl) != eu) begin
        bad++;
        $display("FAIL %s addr=%h: got type=%0d undef=%0d expected type=%0d undef=%0d",
                 tg, addr, mem_type, undef_ovl, et, eu);
      end
    end
  end

  task automatic step(input logic [PA_W-1:0] a, input string t);
    @(negedge clk);
    addr = a;
    tag  = t;
  endtask

  task automatic set_pair(input int i, input longint base, input longint mask,
                          input int ty, input bit v);
    @(negedge clk);
    var_base[i*FW +: FW] = FW'(base);
    var_mask[i*FW +: FW] = FW'(mask);
    var_type[i*3 +: 3]   = 3'(ty);
    var_valid[i]         = v;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int codes[5] = '{0, 1, 4, 5, 6};
    for (int w = 0; w < 11; w++)
      for (int b = 0; b < 8; b++)
        fix_words[w*64 + b*8 +: 8] = 8'(codes[(w * 3 + b) % 5]) | 8'hA0;
    repeat (3) @(negedge clk);
    tag = "R13";
    rst_n = 1'b1;
    glb_en = 1'b0;
    fix_en = 1'b1;
    set_pair(0, 'h200, 'hFFFE00, 6, 1);
    step('h0, "R1"); step('h250000, "R1"); step('h1234_5000, "R1");
    glb_en = 1'b1;
    step('h00000, "R2"); step('h1FFFF, "R2"); step('h30000, "R2"); step('h7FFFF, "R2");
    step('h80000, "R3"); step('h9C000, "R3"); step('hA0000, "R3"); step('hBFFFF, "R3");
    step('hC0000, "R4"); step('hC7FFF, "R4"); step('hD3000, "R4"); step('hFFFFF, "R4");
    set_pair(1, 'h400, 'hFFFC00, 4, 1);
    step('h1FFFFF, "R12"); step('h200000, "R7"); step('h3FFFFF, "R7");
    step('h400000, "R7"); step('h7FFFFF, "R7"); step('h800000, "R12");
    step('h100000, "R12");
    set_pair(2, 'h000, 'hFFFF00, 5, 1);
    step('h05000, "R6"); step('hF0000, "R6");
    fix_en = 1'b0;
    step('h05000, "R5"); step('hF0000, "R5"); step('h2000, "R5");
    fix_en = 1'b1;
    set_pair(3, 'h200, 'hFFFF00, 6, 1);
    step('h250000, "R8");
    set_pair(3, 'h200, 'hFFFF00, 0, 1);
    step('h250000, "R9"); step('h350000, "R7");
    set_pair(3, 'h200, 'hFFFF00, 4, 1);
    step('h250000, "R10");
    set_pair(3, 'h200, 'hFFFF00, 1, 1);
    step('h250000, "R11"); step('h2FFFFF, "R11");
    set_pair(3, 'h200, 'hFFFF00, 5, 1);
    step('h250000, "R11");
    set_pair(3, 'h200, 'hFFFF00, 1, 0);
    step('h250000, "R7");
    dflt_type = 3'd1;
    step('h9000000, "R12");
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (n % 25 == 0) begin
        for (int i = 0; i < NVAR; i++) begin
          int sz;
          sz = $urandom_range(8, 0);
          var_mask[i*FW +: FW] = FW'(('hFFFFFF << sz));
          var_base[i*FW +: FW] = FW'($urandom_range(255, 0) << sz) & var_mask[i*FW +: FW];
          var_type[i*3 +: 3]   = 3'(codes[$urandom_range(4, 0)]);
          var_valid[i]         = ($urandom_range(2, 0) != 0);
        end
        fix_en = $urandom_range(1, 0);
        glb_en = ($urandom_range(5, 0) != 0);
        dflt_type = 3'(codes[$urandom_range(4, 0)]);
      end
      addr = PA_W'($urandom_range(32'h00FF_FFFF, 0));
      tag  = "R7";
    end
    @(negedge clk);
    rst_n = 1'b0;
    tag = "R13";
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule